// File: doc/BRIEF.md
# Seconds-of-day RTC with day counter and alarm

This block is the timekeeping core of a real-time clock. It counts whole seconds and holds time in two parts. The first part is a seconds-of-day count, split across an 8-bit low register and a 9-bit high register; the full value is the high register shifted left by 8 plus the low register. The second part is a 15-bit day counter. There is no calendar decoding. When the seconds-of-day count reaches 86399, the next second returns it to 0 and advances the day. The day counter wraps from 32767 back to 0.

A base-rate enable input, `phase_en`, feeds a prescaler. Every `PHASES` pulses of it make one second tick. Writing the low time register restarts the prescaler, so the first tick after that write comes a full second later. Software therefore writes the day, then the high register, then the low register, and the time is set exactly at the last write.

An alarm made of a day value and a seconds-of-day value is compared against the time as it stands after each tick. A match sets a sticky alarm status bit. Every tick also sets a sticky update status bit. Both status bits are cleared by writing 1 to them. Each interrupt output is its status bit gated by its own enable bit.

All registers are reached through a single-cycle write port and a combinational read port that share one address. The address map is:

| Address | Register |
|---|---|
| 0 | low time, 8 bits |
| 1 | high time, 9 bits |
| 2 | day, 15 bits |
| 3 | alarm low, 8 bits |
| 4 | alarm high, 9 bits |
| 5 | alarm day, 15 bits |
| 6 | status: bit 0 alarm, bit 1 update |
| 7 | enable: bit 0 alarm, bit 1 update |

Top module: `rtc_day_tod`

## Requirements
- R1: After reset every register at addresses 0 to 7 reads 0, and `alarm_irq` and `update_irq` are low.
- R2: One second tick occurs on every `PHASES`-th `phase_en` pulse (default 4). A write to address 0 restarts this count, so the next tick comes on the `PHASES`-th pulse after that write.
- R3: On a tick below the day limit, the low time register (address 0) increments by 1. The high time register (address 1) increments only when the low register passes from 0xFF to 0x00; otherwise it holds.
- R4: On a tick when the seconds-of-day value {high,low} is 86399 or more, both time registers become 0 and the day register (address 2) increments by 1. The day register does not change without a tick or a write.
- R5: When the day register is 32767 and the time rolls over at the end of a day, the day register becomes 0.
- R6: A write that lands in the same cycle as a tick loads the written register with the write data. The other time registers still take their incremented values, which are computed from the values held before that cycle.
- R7: The alarm status bit (address 6, bit 0) sets on a tick whose resulting day and seconds-of-day equal the alarm registers (addresses 5, 4, 3). After it has been cleared, further ticks that do not match leave it clear.
- R8: Every tick sets the update status bit (address 6, bit 1).
- R9: Writing to address 6 clears each status bit that has a 1 in the write data and leaves bits written with 0 unchanged. If a status bit is set by a tick in the same cycle as it is cleared, it stays set.
- R10: `alarm_irq` equals status bit 0 AND enable bit 0, and `update_irq` equals status bit 1 AND enable bit 1 (enable register at address 7).
- R11: Write data bits above a register's width are ignored. A read returns the register value zero-extended to 15 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_en | input | 1 | Base-rate enable; `PHASES` pulses make one second |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 15 | Write data |
| rdata | output | 15 | Read data of the register at `addr`, zero-extended |
| alarm_irq | output | 1 | Alarm interrupt: status bit 0 AND enable bit 0 |
| update_irq | output | 1 | Update interrupt: status bit 1 AND enable bit 1 |

## Verification
The hardest cases to reach are a register write in the very cycle the prescaler produces a tick, and the end of the 32768-day span. Counting from the top would take billions of seconds. The stimulus instead writes the time registers just below each boundary; because the low register is written last, the prescaler restarts at a known phase. The bench then issues exactly `PHASES-1` quiet pulses, so that the next pulse, sent together with a write, lands on the tick. The same phase control places a status clear on the same edge as an update set, and puts the alarm match exactly one tick after a non-matching tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int LO_W  = 8;
    localparam int HI_W  = 9;
    localparam int DAY_W = 15;
    localparam int TOD_W = LO_W + HI_W;
    localparam int BUS_W = DAY_W;
    localparam int SECS_PER_DAY = 86400;
    localparam logic [TOD_W-1:0] TOD_LAST = TOD_W'(SECS_PER_DAY - 1);

    typedef enum logic [2:0] {
        REG_TOD_LO   = 3'd0,
        REG_TOD_HI   = 3'd1,
        REG_DAY      = 3'd2,
        REG_ALM_LO   = 3'd3,
        REG_ALM_HI   = 3'd4,
        REG_ALM_DAY  = 3'd5,
        REG_IRQ_STAT = 3'd6,
        REG_IRQ_EN   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [DAY_W-1:0] day;
        logic [HI_W-1:0]  hi;
        logic [LO_W-1:0]  lo;
    } rtc_time_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_en,
    input  logic restart,
    output logic sec_tick
);
    localparam int CW = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASES - 1);

    logic [CW-1:0] phase_q;

    always_comb begin
        sec_tick = phase_en && (phase_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (phase_en) begin
            phase_q <= sec_tick ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_day,
    input  logic [BUS_W-1:0] wdata,
    output rtc_time_t        time_now,
    output rtc_time_t        time_nxt
);
    rtc_time_t stepped;
    rtc_time_t base;

    always_comb begin
        stepped = time_now;
        if ({time_now.hi, time_now.lo} >= TOD_LAST) begin
            stepped.lo  = '0;
            stepped.hi  = '0;
            stepped.day = time_now.day + 1'b1;
        end else begin
            stepped.lo = time_now.lo + 1'b1;
            if (time_now.lo == {LO_W{1'b1}}) begin
                stepped.hi = time_now.hi + 1'b1;
            end
        end
    end

    always_comb begin
        base = sec_tick ? stepped : time_now;
        time_nxt.lo  = wr_lo  ? wdata[LO_W-1:0]  : base.lo;
        time_nxt.hi  = wr_hi  ? wdata[HI_W-1:0]  : base.hi;
        time_nxt.day = wr_day ? wdata[DAY_W-1:0] : base.day;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_now <= '0;
        end else begin
            time_now <= time_nxt;
        end
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_day,
    input  logic [BUS_W-1:0] wdata,
    input  rtc_time_t        time_nxt,
    output rtc_time_t        alarm_q,
    output logic             alarm_hit
);
    always_comb begin
        alarm_hit = sec_tick && (time_nxt == alarm_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else begin
            if (wr_lo)  alarm_q.lo  <= wdata[LO_W-1:0];
            if (wr_hi)  alarm_q.hi  <= wdata[HI_W-1:0];
            if (wr_day) alarm_q.day <= wdata[DAY_W-1:0];
        end
    end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alarm_hit,
    input  logic       sec_tick,
    input  logic       wr_stat,
    input  logic       wr_mask,
    input  logic [1:0] wbits,
    output logic [1:0] stat_q,
    output logic [1:0] en_q,
    output logic       alarm_irq,
    output logic       update_irq
);
    logic [1:0] clr;
    logic [1:0] set;

    always_comb begin
        clr = wr_stat ? wbits : 2'b00;
        set = {sec_tick, alarm_hit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 2'b00;
            en_q   <= 2'b00;
        end else begin
            stat_q <= (stat_q & ~clr) | set;
            if (wr_mask) en_q <= wbits;
        end
    end

    always_comb begin
        alarm_irq  = stat_q[0] & en_q[0];
        update_irq = stat_q[1] & en_q[1];
    end
endmodule

// File: rtl/rtc_day_tod.sv
module rtc_day_tod
    import rtc_pkg::*;
#(
    parameter int PHASES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_en,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             alarm_irq,
    output logic             update_irq
);
    logic      wr_lo, wr_hi, wr_day;
    logic      wr_alo, wr_ahi, wr_aday;
    logic      wr_stat, wr_mask;
    logic      sec_tick;
    logic      alarm_hit;
    logic [1:0] irq_stat;
    logic [1:0] irq_en;
    rtc_time_t time_now;
    rtc_time_t time_nxt;
    rtc_time_t alarm_q;
    reg_sel_e  sel;

    assign sel = reg_sel_e'(addr);

    always_comb begin
        wr_lo = 1'b0; wr_hi = 1'b0; wr_day = 1'b0;
        wr_alo = 1'b0; wr_ahi = 1'b0; wr_aday = 1'b0;
        wr_stat = 1'b0; wr_mask = 1'b0;
        if (wr_en) begin
            unique case (sel)
                REG_TOD_LO:   wr_lo   = 1'b1;
                REG_TOD_HI:   wr_hi   = 1'b1;
                REG_DAY:      wr_day  = 1'b1;
                REG_ALM_LO:   wr_alo  = 1'b1;
                REG_ALM_HI:   wr_ahi  = 1'b1;
                REG_ALM_DAY:  wr_aday = 1'b1;
                REG_IRQ_STAT: wr_stat = 1'b1;
                REG_IRQ_EN:   wr_mask = 1'b1;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            REG_TOD_LO:   rdata = BUS_W'(time_now.lo);
            REG_TOD_HI:   rdata = BUS_W'(time_now.hi);
            REG_DAY:      rdata = BUS_W'(time_now.day);
            REG_ALM_LO:   rdata = BUS_W'(alarm_q.lo);
            REG_ALM_HI:   rdata = BUS_W'(alarm_q.hi);
            REG_ALM_DAY:  rdata = BUS_W'(alarm_q.day);
            REG_IRQ_STAT: rdata = BUS_W'(irq_stat);
            REG_IRQ_EN:   rdata = BUS_W'(irq_en);
        endcase
    end

    rtc_prescaler #(.PHASES(PHASES)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_en (phase_en),
        .restart  (wr_lo),
        .sec_tick (sec_tick)
    );

    rtc_time_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wr_day   (wr_day),
        .wdata    (wdata),
        .time_now (time_now),
        .time_nxt (time_nxt)
    );

    rtc_alarm_unit u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .wr_lo     (wr_alo),
        .wr_hi     (wr_ahi),
        .wr_day    (wr_aday),
        .wdata     (wdata),
        .time_nxt  (time_nxt),
        .alarm_q   (alarm_q),
        .alarm_hit (alarm_hit)
    );

    rtc_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .alarm_hit  (alarm_hit),
        .sec_tick   (sec_tick),
        .wr_stat    (wr_stat),
        .wr_mask    (wr_mask),
        .wbits      (wdata[1:0]),
        .stat_q     (irq_stat),
        .en_q       (irq_en),
        .alarm_irq  (alarm_irq),
        .update_irq (update_irq)
    );
endmodule

// File: rtl/rtc_day_tod_chk.sv
module rtc_day_tod_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       wr_lo,
    input logic       wr_hi,
    input logic       wr_day,
    input logic       alarm_hit,
    input logic [1:0] stat,
    input rtc_time_t  now,
    input logic       alarm_irq,
    input logic       update_irq
);
    logic [TOD_W-1:0] tod;
    assign tod = {now.hi, now.lo};

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!alarm_irq && !update_irq)); // R1

    AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_lo && (tod < TOD_LAST)) |=> (now.lo == $past(now.lo) + 8'd1)); // R3

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi && !(sec_tick && ((now.lo == 8'hFF) || (tod >= TOD_LAST)))) |=> $stable(now.hi)); // R3

    AST_DAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_day && !sec_tick) |=> $stable(now.day)); // R4

    AST_UPD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> stat[1]); // R8

    AST_ALM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> $past(alarm_hit)); // R7

    AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_irq |-> stat[0]) and (update_irq |-> stat[1])); // R10
endmodule

bind rtc_day_tod rtc_day_tod_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .wr_day     (wr_day),
    .alarm_hit  (alarm_hit),
    .stat       (irq_stat),
    .now        (time_now),
    .alarm_irq  (alarm_irq),
    .update_irq (update_irq)
);

// File: tb/rtc_day_tod_test.sv
module rtc_day_tod_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [14:0] wdata = 15'd0;
    logic [14:0] rdata;
    logic        alarm_irq;
    logic        update_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [2:0]  a;
        logic [14:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #5 clk = ~clk;

    rtc_day_tod #(.PHASES(4)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_en   (phase_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .alarm_irq  (alarm_irq),
        .update_irq (update_irq)
    );

    // Monitor: pops one expected item per falling edge and compares.
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            sb_item_t it;
            logic [14:0] act;
            it = sb.pop_front();
            act = (it.kind == 0) ? rdata : {13'd0, alarm_irq, update_irq};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d addr=%0d actual=0x%0h expected=0x%0h",
                         it.tag, it.kind, it.a, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [14:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            phase_en = 1'b1;
            step();
            phase_en = 1'b0;
        end
    endtask

    task automatic collide(input logic [2:0] a, input logic [14:0] d);
        phase_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        step();
        phase_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [14:0] e, input string tag);
        sb_item_t it;
        addr = a;
        it.kind = 0; it.a = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    // Expected pins packed as {alarm_irq, update_irq}.
    task automatic pins(input logic [1:0] e, input string tag);
        sb_item_t it;
        it.kind = 1; it.a = addr; it.exp = {13'd0, e}; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state of all registers and both pins
        for (int i = 0; i < 8; i++) rd(3'(i), 15'd0, "R1");
        pins(2'b00, "R1");

        // R11: upper write bits ignored, zero-extended reads
        wr(3'd0, 15'h7FAB); rd(3'd0, 15'h00AB, "R11");
        wr(3'd1, 15'h7FFF); rd(3'd1, 15'h01FF, "R11");
        wr(3'd2, 15'h7FFF); rd(3'd2, 15'h7FFF, "R11");
        wr(3'd7, 15'h7FFF); rd(3'd7, 15'h0003, "R11");
        wr(3'd7, 15'd0);
        wr(3'd5, 15'h0100);

        // R2 and R3: prescaler phase and low/high stepping
        wr(3'd2, 15'd0); wr(3'd1, 15'd5); wr(3'd0, 15'h00FE);
        pulse(3); rd(3'd0, 15'h00FE, "R2");
        pulse(1); rd(3'd0, 15'h00FF, "R3"); rd(3'd1, 15'd5, "R3");
        pulse(4); rd(3'd0, 15'h0000, "R3"); rd(3'd1, 15'd6, "R3");

        // R2: low write restarts the sub-second phase
        pulse(2); wr(3'd0, 15'h0010);
        pulse(3); rd(3'd0, 15'h0010, "R2");
        pulse(1); rd(3'd0, 15'h0011, "R2");

        // R4: end of day rolls to next day
        wr(3'd2, 15'd7); wr(3'd1, 15'h0151); wr(3'd0, 15'h007F);
        pulse(4);
        rd(3'd0, 15'd0, "R4"); rd(3'd1, 15'd0, "R4"); rd(3'd2, 15'd8, "R4");

        // R5: last representable second wraps the day to 0
        wr(3'd2, 15'h7FFF); wr(3'd1, 15'h0151); wr(3'd0, 15'h007F);
        pulse(4);
        rd(3'd2, 15'd0, "R5"); rd(3'd1, 15'd0, "R5"); rd(3'd0, 15'd0, "R5");

        // R6: write in the tick cycle
        wr(3'd2, 15'd2); wr(3'd1, 15'd3); wr(3'd0, 15'h00FF);
        pulse(3); collide(3'd1, 15'h0020);
        rd(3'd0, 15'd0, "R6"); rd(3'd1, 15'h0020, "R6"); rd(3'd2, 15'd2, "R6");
        wr(3'd0, 15'h00FF);
        pulse(3); collide(3'd0, 15'h0055);
        rd(3'd0, 15'h0055, "R6"); rd(3'd1, 15'h0021, "R6");

        // R8 and R10: update status set, pins gated by enables
        rd(3'd6, 15'd2, "R8");
        pins(2'b00, "R10");
        wr(3'd7, 15'd2);
        pins(2'b01, "R10");

        // R9: write-one-to-clear
        wr(3'd6, 15'd0); rd(3'd6, 15'd2, "R9");
        wr(3'd6, 15'd2); rd(3'd6, 15'd0, "R9");
        pins(2'b00, "R10");

        // R7: alarm fires once on the matching tick
        wr(3'd5, 15'd9); wr(3'd4, 15'd0); wr(3'd3, 15'd5);
        wr(3'd2, 15'd9); wr(3'd1, 15'd0); wr(3'd0, 15'd3);
        wr(3'd6, 15'd3); wr(3'd7, 15'd1);
        pulse(4);
        rd(3'd0, 15'd4, "R7"); rd(3'd6, 15'd2, "R7"); pins(2'b00, "R7");
        pulse(4);
        rd(3'd0, 15'd5, "R7"); rd(3'd6, 15'd3, "R7"); pins(2'b10, "R7");
        wr(3'd6, 15'd1); pins(2'b00, "R7");
        pulse(4);
        rd(3'd0, 15'd6, "R7"); rd(3'd6, 15'd2, "R7"); pins(2'b00, "R7");

        // R9: a set in the same cycle as a clear wins
        wr(3'd6, 15'd3); rd(3'd6, 15'd0, "R9");
        pulse(3); collide(3'd6, 15'd2);
        rd(3'd6, 15'd2, "R9");

        step();
        finish_run();
    end
endmodule